// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block is the digital tail of a ten-stage pipelined analog-to-digital converter. Nine front stages each produce a 2-bit code that carries one redundant bit, and a last stage produces a single bit. Neighbouring stages resolve on opposite clock phases, so the codes that belong to one sample reach the block staggered in time. Each stage's code goes through its own deskew register chain, sized so that all nineteen raw bits of a sample meet in one cycle.

Once the bits are aligned, the block adds the overlapping stage codes with binary weights, which absorbs small decision errors made in the front stages. It then applies the selected output coding and passes the word through two output registers. The delay from a sample to its word is fixed at seven clocks. After that delay, one word leaves on every clock for as long as samples keep arriving.

The output is a valid-qualified stream with no ready signal. The analog pipeline cannot be stalled, so there is no back-pressure. A consumer must take each word in the cycle where `d_valid` is high, and a word that is not taken is lost.

Top module: `pipe_adc_backend`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge `d_data` reads 0, `d_valid` reads 0 and `code_err` reads 0.
- R2: Front stage k (k = 1..9) occupies bits [2k-1:2k-2] of `s_codes`. The block takes stage k's code for a sample floor((k-1)/2) clocks after the edge that takes `s_valid` for that sample. It takes the last-stage bit 4 clocks after that edge.
- R3: The corrected value is the sum, over stages k = 1..9, of code_k times 2^(9-k), plus the last-stage bit. The range is 0 to 1023.
- R4: Two different code sets with the same weighted sum give the same word. For example, stage1=1 with stage2=0 and stage1=0 with stage2=2 both contribute 256.
- R5: A sample whose `s_valid` is taken at edge e appears with `d_valid` high after edge e+7. `d_valid` stays low for the first seven edges after reset.
- R6: Samples taken on consecutive edges leave on consecutive clocks. A gap in `s_valid` leaves a gap of the same length in `d_valid`.
- R7: `fmt_twos` is taken one edge before the word appears, at edge e+6. When it is 0 the word is offset binary. When it is 1 the word is two's complement, which is offset binary with bit 9 inverted.
- R8: A stage code of 3 in a valid sample is treated as 2.
- R9: `code_err` goes high after edge e+5 for a valid sample that contains any code of 3. It stays high until reset. Codes driven while no valid sample occupies a stage do not set it.
- R10: The word leaving the correction stage reaches `d_data` through exactly two output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | A new sample is present at stage 1 this cycle |
| s_codes | input | 18 | Nine 2-bit front-stage codes, stage 1 in the low bits |
| s_last_bit | input | 1 | Last-stage 1-bit decision |
| fmt_twos | input | 1 | Output coding select: 0 offset binary, 1 two's complement |
| d_data | output | 10 | Corrected output word |
| d_valid | output | 1 | `d_data` holds a word this cycle |
| code_err | output | 1 | Sticky flag: an illegal stage code was seen |

## Verification
Clamping an illegal code and inverting the sign bit for two's complement can both act on the same word. They also fall in the same cycle as the first rise of the sticky error flag. The bench provokes this with one sample that carries a code of 3 in stages 1 and 4, with format select high when that word leaves. It judges the result against an arithmetic model that first clamps the codes, then sums them, then flips bit 9. In the same run it checks the exact edge on which `code_err` rises. A second overlap arises because format select changes while a back-to-back stream is in flight. That case is judged by applying the format value taken one edge before each word appears.

// File: rtl/adcbe_pkg.sv
package adcbe_pkg;
  // Clock offset at which front stage index i (0-based) delivers its code
  function automatic int stage_skew(input int idx);
    return idx / 2;
  endfunction
endpackage

// File: rtl/adcbe_deskew.sv
module adcbe_deskew #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) taps[0] <= '0;
    else     taps[0] <= din;
  end

  generate
    for (genvar gt = 1; gt < DEPTH; gt++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) taps[gt] <= '0;
        else     taps[gt] <= taps[gt-1];
      end
    end
  endgenerate

  assign dout = taps[DEPTH-1];
endmodule

// File: rtl/adcbe_merge.sv
module adcbe_merge #(
  parameter int N_FRONT = 9
) (
  input  logic [2*N_FRONT-1:0] codes,
  input  logic                 last_bit,
  output logic [N_FRONT:0]     word,
  output logic                 illegal
);
  localparam int OW = N_FRONT + 1;

  always_comb begin
    logic [OW-1:0] acc;
    logic [1:0]    c;
    acc     = '0;
    illegal = 1'b0;
    for (int i = 0; i < N_FRONT; i++) begin
      c = codes[2*i +: 2];
      if (c == 2'd3) begin
        c       = 2'd2;
        illegal = 1'b1;
      end
      acc = acc + (OW'(c) << (N_FRONT - 1 - i));
    end
    word = acc + OW'(last_bit);
  end
endmodule

// File: rtl/adcbe_outreg.sv
module adcbe_outreg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         vin,
  output logic [W-1:0] dout,
  output logic         vout
);
  logic [W-1:0] hold_d;
  logic         hold_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_d <= '0;
      hold_v <= 1'b0;
      dout   <= '0;
      vout   <= 1'b0;
    end else begin
      hold_d <= din;
      hold_v <= vin;
      dout   <= hold_d;
      vout   <= hold_v;
    end
  end
endmodule

// File: rtl/pipe_adc_backend.sv
module pipe_adc_backend #(
  parameter int N_FRONT = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic [2*N_FRONT-1:0] s_codes,
  input  logic                 s_last_bit,
  input  logic                 fmt_twos,
  output logic [N_FRONT:0]     d_data,
  output logic                 d_valid,
  output logic                 code_err
);
  import adcbe_pkg::*;

  localparam int OW   = N_FRONT + 1;
  localparam int MAXD = N_FRONT / 2;

  logic [2*N_FRONT-1:0] al_codes;
  logic                 al_last;
  logic                 al_valid;
  logic [OW-1:0]        raw_sum;
  logic                 any_bad;
  logic [OW-1:0]        sum_q;
  logic                 sum_v;
  logic [OW-1:0]        fmt_word;

  // Per-stage deskew: earlier stages wait longer
  generate
    for (genvar gi = 0; gi < N_FRONT; gi++) begin : g_stage
      adcbe_deskew #(.W(2), .DEPTH(MAXD - stage_skew(gi) + 1)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (s_codes[2*gi +: 2]),
        .dout (al_codes[2*gi +: 2])
      );
    end
  endgenerate

  adcbe_deskew #(.W(1), .DEPTH(MAXD - stage_skew(N_FRONT) + 1)) u_last_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (s_last_bit),
    .dout (al_last)
  );

  adcbe_deskew #(.W(1), .DEPTH(MAXD + 1)) u_valid_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (s_valid),
    .dout (al_valid)
  );

  adcbe_merge #(.N_FRONT(N_FRONT)) u_merge (
    .codes    (al_codes),
    .last_bit (al_last),
    .word     (raw_sum),
    .illegal  (any_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      sum_v    <= 1'b0;
      code_err <= 1'b0;
    end else begin
      sum_q <= raw_sum;
      sum_v <= al_valid;
      if (al_valid && any_bad) code_err <= 1'b1;
    end
  end

  assign fmt_word = fmt_twos ? {~sum_q[OW-1], sum_q[OW-2:0]} : sum_q;

  adcbe_outreg #(.W(OW)) u_out (
    .clk  (clk),
    .rst  (rst),
    .din  (fmt_word),
    .vin  (sum_v),
    .dout (d_data),
    .vout (d_valid)
  );
endmodule

// File: rtl/adcbe_checker.sv
module adcbe_checker #(
  parameter int N_FRONT = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             d_valid,
  input logic [N_FRONT:0] d_data,
  input logic             code_err,
  input logic [N_FRONT:0] fmt_word
);
  logic [3:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 15) since_rst <= since_rst + 4'd1;
  end

  // R5: fixed seven-clock latency on the valid flag
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 8) |-> (d_valid == $past(s_valid, 8)));

  // R5: nothing emerges before the pipeline has filled after reset
  a_r5_quiet_start: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 8) |-> !d_valid);

  // R9: error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(code_err) |-> code_err);

  // R10: two output registers between correction and pins
  a_r10_double_buf: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (d_data == $past(fmt_word, 2)));
endmodule

bind pipe_adc_backend adcbe_checker #(.N_FRONT(N_FRONT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .d_valid  (d_valid),
  .d_data   (d_data),
  .code_err (code_err),
  .fmt_word (fmt_word)
);

// File: tb/pipe_adc_backend_bench.sv
`timescale 1ns/1ps
module pipe_adc_backend_bench;
  localparam int NF = 9;
  localparam int MAXS = 1200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic [2*NF-1:0] s_codes = '0;
  logic          s_last_bit = 1'b0;
  logic          fmt_twos = 1'b0;
  logic [NF:0]   d_data;
  logic          d_valid;
  logic          code_err;

  int total = 0;
  int bad   = 0;

  logic [2*NF-1:0] sc  [MAXS];
  logic            sfb [MAXS];
  logic            sv  [MAXS];
  bit              spec[MAXS];
  int              fmt_off = 0;

  always #10 clk = ~clk;

  pipe_adc_backend #(.N_FRONT(NF)) u_pipe_adc_backend (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_codes(s_codes),
    .s_last_bit(s_last_bit), .fmt_twos(fmt_twos),
    .d_data(d_data), .d_valid(d_valid), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit fmt_at(input int e);
    return (((e + fmt_off) / 40) % 2) == 1;
  endfunction

  function automatic int model(input int s, input bit tw);
    int acc = 0;
    for (int i = 0; i < NF; i++) begin
      int c = int'(sc[s][2*i +: 2]);
      if (c == 3) c = 2;
      acc += c << (NF - 1 - i);
    end
    acc += int'(sfb[s]);
    if (tw) acc = acc ^ 512;
    return acc;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(d_data == '0, "R1", "reset data", int'(d_data), 0);
    chk(d_valid == 1'b0, "R1", "reset valid", int'(d_valid), 0);
    chk(code_err == 1'b0, "R1", "reset err", int'(code_err), 0);
    rst = 1'b0;
  endtask

  // Edge c: stage i carries sample c - i/2; last bit carries sample c - 4
  task automatic run(input int ns, input int err_s);
    for (int c = 0; c < ns + 10; c++) begin
      s_valid  = (c < ns) ? sv[c] : 1'b0;
      fmt_twos = fmt_at(c);
      for (int i = 0; i < NF; i++) begin
        int sm = c - i / 2;
        if (sm >= 0 && sm < ns && sv[sm]) s_codes[2*i +: 2] = sc[sm][2*i +: 2];
        else                              s_codes[2*i +: 2] = 2'b11;
      end
      begin
        int sl = c - 4;
        s_last_bit = (sl >= 0 && sl < ns && sv[sl]) ? sfb[sl] : 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      begin
        int  sm = c - 7;
        bit  ev = (sm >= 0 && sm < ns) ? sv[sm] : 1'b0;
        bit  ee = (err_s >= 0) && (c >= err_s + 5);
        chk(d_valid == ev, "R5/R6", "valid", int'(d_valid), int'(ev));
        chk(code_err == ee, "R9", "err flag", int'(code_err), int'(ee));
        if (ev) begin
          bit    tw  = fmt_at(c - 1);
          int    exp = model(sm, tw);
          string req = (sm == err_s) ? "R8/R7" : spec[sm] ? "R4" : tw ? "R7" : "R3/R2";
          chk(int'(d_data) == exp, req, "data", int'(d_data), exp);
        end
      end
    end
  endtask

  initial begin
    // Phase A: long sweep with gaps, format toggling every 40 edges
    for (int s = 0; s < MAXS; s++) begin
      sv[s]   = (s % 13 != 5) && (s % 7 != 3);
      sfb[s]  = s[0];
      spec[s] = 1'b0;
      for (int i = 0; i < NF; i++)
        sc[s][2*i +: 2] = 2'((s * (i + 3) + (i * s) / 5 + i) % 3);
    end
    // R4: redundant decompositions with equal weight
    sc[20] = '0; sc[20][1:0] = 2'd1; sfb[20] = 1'b0;
    sc[21] = '0; sc[21][3:2] = 2'd2; sfb[21] = 1'b0;
    sc[22] = '0; sc[22][5:4] = 2'd1; sc[22][3:2] = 2'd1; sfb[22] = 1'b1;
    sc[23] = '0; sc[23][3:2] = 2'd1; sc[23][7:6] = 2'd2; sfb[23] = 1'b1;
    for (int i = 0; i < NF; i++) sc[30][2*i +: 2] = 2'd2;
    sfb[30] = 1'b1;
    sc[31] = '0; sfb[31] = 1'b0;
    for (int s = 20; s < 32; s++) if (s < 24 || s > 29) begin sv[s] = 1'b1; spec[s] = 1'b1; end
    fmt_off = 0;
    do_reset();
    run(1100, -1);

    // Phase B: illegal codes clamped, format inverted on the same word, flag rises
    for (int s = 0; s < 40; s++) begin
      sv[s] = 1'b1; spec[s] = 1'b0; sfb[s] = s[1];
      for (int i = 0; i < NF; i++) sc[s][2*i +: 2] = 2'((s + 2 * i) % 3);
    end
    for (int i = 0; i < NF; i++) sc[15][2*i +: 2] = 2'd2;
    sc[15][1:0] = 2'd3;
    sc[15][7:6] = 2'd3;
    sfb[15] = 1'b0;
    fmt_off = 20;
    do_reset();
    run(40, 15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule